// File: doc/BRIEF.md
# SPI Master/Slave Port with Fault Detection

This block is a byte-wide serial port for a four-wire synchronous bus: serial clock, master-out data, master-in data and an active-low select. Software programs it through a small register window of three locations (control, status, data). In master mode, writing the data location launches an 8-bit exchange, most significant bit first. The block generates the serial clock at one of four division ratios of the system clock. In slave mode, the same shift logic is clocked by the incoming serial clock, but only while the select input is held low.

Clock idle level and sampling phase come from two control bits. Software may change them between bytes to talk to devices with different clocking needs. Two error detectors protect the bus. A data write that lands during a live exchange raises a collision flag and is dropped. If the select input is pulled low while the block is master, another master is driving the bus: the block raises a fault flag, clears its own master bit, and releases the clock and master-out drivers.

Register map: location 0 is control, with bit 0 enable, bit 1 master, bit 2 clock idle level, bit 3 phase and bits 5:4 the rate code. Location 1 is status, with bit 0 byte done, bit 1 collision and bit 2 fault. Location 2 is data: a write supplies the transmit byte and a read returns the last received byte. Read data is combinational from the address.

Top module: `spi_port`

## Requirements
- R1: After reset, control and status read as 0, all three output enables are low and the serial clock output is low.
- R2: In master mode, a data write while idle sends the byte MSB first on master-out over 16 clock edges, latches the 8 received bits into the read buffer and sets status bit 0.
- R3: Rate code 0, 1, 2 or 3 gives a serial clock of the system clock divided by 2, 4, 16 or 32. The done flag appears 8 times the divisor in system clocks after the clock edge that captures the data write.
- R4: Control bit 2 sets the idle level of the serial clock. Control bit 3 selects sampling on the leading edge (0) or the trailing edge (1). All four combinations exchange bytes correctly, and the clock returns to its idle level after each byte.
- R5: In slave mode with select low, incoming clock edges shift in the master-out data and present the preloaded byte MSB first on master-in. After 16 edges the received byte is latched and status bit 0 is set.
- R6: In slave mode, clock edges arriving while select is high are ignored: no done flag, no shift, and the preloaded byte is still sent intact on the next selected exchange.
- R7: A data write during an exchange sets status bit 1. The written byte is discarded and the exchange in progress completes unchanged.
- R8: Status bits 0 and 1 clear only when a status read is followed by a data-location access; a data access alone leaves them set.
- R9: Select driven low while enabled as master sets status bit 2, clears control bit 1, lowers the clock and master-out enables, and aborts the exchange without a done flag.
- R10: The fault flag clears only when a status read is followed by a control write; a control write alone leaves it set.
- R11: The clock and master-out enables are high only for an enabled master. The master-in enable is high only for an enabled slave whose select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register location select |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (drives flag clearing) |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data for busAddr |
| sckIn | input | 1 | Serial clock from the bus (slave mode) |
| sckOut | output | 1 | Generated serial clock (master mode) |
| sckOe | output | 1 | Serial clock driver enable |
| mosiIn | input | 1 | Master-out data from the bus (slave mode) |
| mosiOut | output | 1 | Master-out data driven by this block |
| mosiOe | output | 1 | Master-out driver enable |
| misoIn | input | 1 | Master-in data from the bus (master mode) |
| misoOut | output | 1 | Master-in data driven by this block |
| misoOe | output | 1 | Master-in driver enable |
| ssN | input | 1 | Active-low select / fault sense |

## Verification
The hardest states to reach are the two that interrupt a live byte: a collision write, and a select pulled low partway through a master exchange. To hit these, the bench runs the master at a slow rate code, so each bit lasts many system clocks. It counts cycles from the launching write and injects the second data write or the select drop well inside the byte. It then checks that the original byte still emerges intact, or that the drivers fall and no done flag appears. The flag-clearing order is exercised by accessing the locations both without and with the preceding status read.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
  localparam int CTL_W  = 6;
  localparam int HALF_W = 5;
  localparam int CTL_LOC  = 0;
  localparam int STAT_LOC = 1;
  localparam int DATA_LOC = 2;

  typedef struct packed {
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctlFields_t;

  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
    logic finishDirect;
  } dpStrobe_t;

  // system clocks per half serial-clock period for each rate code
  function automatic logic [HALF_W-1:0] halfOf(input logic [1:0] code);
    case (code)
      2'd0:    return HALF_W'(1);
      2'd1:    return HALF_W'(2);
      2'd2:    return HALF_W'(8);
      default: return HALF_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/spi_port_ctrl.sv
`timescale 1ns/1ps
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CTL_W-1:0]  ctlWdata,
  input  logic              sckIn,
  input  logic              ssN,
  output dpStrobe_t         strobe,
  output logic              isMaster,
  output logic [DATA_W-1:0] ctlReg,
  output logic [DATA_W-1:0] statReg,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOe,
  output logic              misoOe
);
  localparam int EDGES  = 2 * DATA_W;
  localparam int CNT_W  = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

  ctlFields_t        cfg;
  logic              done, wcol, modf, statusSeen;
  logic              busy, sckLvl;
  logic [CNT_W-1:0]  edgeCnt;
  logic [HALF_W-1:0] halfCnt, halfLast;
  logic              sck1, sck2, sckPrev, ss1, ss2;

  logic ctlWr, dataWr, dataRd, statRd, clearXfer;
  logic faultNow, slvSel, mEvt, sEvt, evt, inFlight, collide, start;
  logic isSample, lastEdge;

  always_comb begin
    ctlWr     = busWr && (busAddr == ADDR_W'(CTL_LOC));
    dataWr    = busWr && (busAddr == ADDR_W'(DATA_LOC));
    dataRd    = busRd && (busAddr == ADDR_W'(DATA_LOC));
    statRd    = busRd && (busAddr == ADDR_W'(STAT_LOC));
    clearXfer = statusSeen && (dataWr || dataRd);
    halfLast  = halfOf(cfg.rate) - HALF_W'(1);
    faultNow  = cfg.en && cfg.master && !ss2;
    slvSel    = cfg.en && !cfg.master && !ss2;
    mEvt      = busy && (halfCnt == halfLast) && !faultNow;
    sEvt      = slvSel && (sck2 != sckPrev);
    evt       = mEvt || sEvt;
    inFlight  = cfg.master ? busy : (edgeCnt != '0);
    collide   = dataWr && inFlight;
    start     = dataWr && !inFlight && cfg.en && cfg.master && !faultNow;
    isSample  = cfg.cpha ? edgeCnt[0] : !edgeCnt[0];
    lastEdge  = (edgeCnt == LAST_EDGE);
    strobe.load         = dataWr && !inFlight;
    strobe.sample       = evt && isSample && !lastEdge;
    strobe.shift        = evt && !isSample && !lastEdge && (edgeCnt != '0);
    strobe.finish       = evt && lastEdge;
    strobe.finishDirect = cfg.cpha;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sck1, sck2, sckPrev} <= '0;
      {ss1, ss2}            <= 2'b11;
    end else begin
      sck1    <= sckIn;
      sck2    <= sck1;
      sckPrev <= sck2;
      ss1     <= ssN;
      ss2     <= ss1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg        <= '0;
      done       <= 1'b0;
      wcol       <= 1'b0;
      modf       <= 1'b0;
      statusSeen <= 1'b0;
    end else begin
      if (ctlWr) cfg <= ctlFields_t'(ctlWdata);
      if (faultNow) cfg.master <= 1'b0;
      if (statRd) statusSeen <= 1'b1;
      else if (busRd || busWr) statusSeen <= 1'b0;
      if (strobe.finish) done <= 1'b1;
      else if (clearXfer) done <= 1'b0;
      if (collide) wcol <= 1'b1;
      else if (clearXfer) wcol <= 1'b0;
      if (faultNow) modf <= 1'b1;
      else if (statusSeen && ctlWr) modf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sckLvl  <= 1'b0;
      edgeCnt <= '0;
      halfCnt <= '0;
    end else begin
      if (faultNow) busy <= 1'b0;
      else if (start) busy <= 1'b1;
      else if (mEvt && lastEdge) busy <= 1'b0;

      if (!busy || faultNow) sckLvl <= 1'b0;
      else if (mEvt) sckLvl <= !sckLvl;

      if (!busy || halfCnt == halfLast) halfCnt <= '0;
      else halfCnt <= halfCnt + HALF_W'(1);

      if (faultNow || start || (!cfg.master && !slvSel)) edgeCnt <= '0;
      else if (evt) edgeCnt <= lastEdge ? '0 : edgeCnt + CNT_W'(1);
    end
  end

  always_comb begin
    isMaster = cfg.master;
    ctlReg   = DATA_W'(cfg);
    statReg  = DATA_W'({modf, wcol, done});
    sckOut   = cfg.cpol ^ sckLvl;
    sckOe    = cfg.en && cfg.master;
    mosiOe   = cfg.en && cfg.master;
    misoOe   = slvSel;
  end

  p_fault_drops_master_r9: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> (!cfg.master && modf && !busy));
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sckLvl == 1'b0));
  p_collide_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (collide && busy && !faultNow && !(mEvt && lastEdge)) |=> busy);
  p_start_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (busy && edgeCnt == '0 && !sckLvl));
endmodule

// File: rtl/spi_port_dp.sv
`timescale 1ns/1ps
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              isMaster,
  input  logic [DATA_W-1:0] wrData,
  input  logic              misoIn,
  input  logic              mosiIn,
  output logic              txBit,
  output logic [DATA_W-1:0] rxBuf
);
  logic [DATA_W-1:0] shReg;
  logic              rxBit, mosi1, mosi2, inBit, tailBit;

  always_comb begin
    inBit   = isMaster ? misoIn : mosi2;
    tailBit = strobe.finishDirect ? inBit : rxBit;
    txBit   = shReg[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      rxBit <= 1'b0;
      rxBuf <= '0;
      mosi1 <= 1'b0;
      mosi2 <= 1'b0;
    end else begin
      mosi1 <= mosiIn;
      mosi2 <= mosi1;
      if (strobe.sample) rxBit <= inBit;
      if (strobe.load) shReg <= wrData;
      else if (strobe.shift) shReg <= {shReg[DATA_W-2:0], rxBit};
      if (strobe.finish) rxBuf <= {shReg[DATA_W-2:0], tailBit};
    end
  end

  p_rxbuf_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(rxBuf));
endmodule

// File: rtl/spi_port.sv
`timescale 1ns/1ps
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  input  logic              ssN
);
  dpStrobe_t         strobe;
  logic              isMaster, txBit;
  logic [DATA_W-1:0] ctlReg, statReg, rxBuf;

  spi_port_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .ctlWdata(busWdata[CTL_W-1:0]), .sckIn(sckIn), .ssN(ssN),
    .strobe(strobe), .isMaster(isMaster), .ctlReg(ctlReg), .statReg(statReg),
    .sckOut(sckOut), .sckOe(sckOe), .mosiOe(mosiOe), .misoOe(misoOe)
  );

  spi_port_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isMaster(isMaster),
    .wrData(busWdata), .misoIn(misoIn), .mosiIn(mosiIn),
    .txBit(txBit), .rxBuf(rxBuf)
  );

  always_comb begin
    mosiOut = txBit;
    misoOut = txBit;
    case (busAddr)
      ADDR_W'(CTL_LOC):  busRdata = ctlReg;
      ADDR_W'(STAT_LOC): busRdata = statReg;
      ADDR_W'(DATA_LOC): busRdata = rxBuf;
      default:           busRdata = '0;
    endcase
  end

  p_oe_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(misoOe && (sckOe || mosiOe)));
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  logic       clk = 1'b0, rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic       sckIn = 1'b0, sckOut, sckOe;
  logic       mosiIn = 1'b0, mosiOut, mosiOe;
  logic       misoIn, misoOut, misoOe;
  logic       ssN = 1'b1;
  logic       loopInv = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  logic       mcpol = 1'b0, mcpha = 1'b0, monPrev = 1'b0;
  int         monCnt = 0;
  logic [7:0] monByte = '0;

  always #4 clk = ~clk;
  assign misoIn = loopInv ? ~mosiOut : mosiOut;

  spi_port dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .sckIn(sckIn), .sckOut(sckOut),
    .sckOe(sckOe), .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .ssN(ssN)
  );

  // bench-side receiver of the master-out line
  always @(negedge clk) begin
    if (sckOut !== monPrev) begin
      monCnt = monCnt + 1;
      if (mcpha ? (sckOut === mcpol) : (sckOut !== mcpol))
        monByte = {monByte[6:0], mosiOut};
    end
    monPrev = sckOut;
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    tick(1);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    tick(1);
    busRd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic clearFlags();
    logic [7:0] d;
    busRead(2'd1, d);
    busRead(2'd2, d);
  endtask

  task automatic testReset();
    logic [7:0] d;
    peek(2'd0, d); check(d == 8'h00, "R1 control after reset", d, 8'h00);
    peek(2'd1, d); check(d == 8'h00, "R1 status after reset", d, 8'h00);
    check({sckOe, mosiOe, misoOe, sckOut} == 4'b0000, "R1 enables and clock", {sckOe, mosiOe, misoOe, sckOut}, 4'b0000);
  endtask

  task automatic masterXfer(input logic cpol, input logic cpha, input logic [1:0] rate,
                            input logic [7:0] tx, input logic inv);
    logic [7:0] d, rx, expRx;
    int cycles, half;
    half = (rate == 2'd0) ? 1 : (rate == 2'd1) ? 2 : (rate == 2'd2) ? 8 : 16;
    loopInv = inv;
    clearFlags();
    busWrite(2'd0, {2'b00, rate, cpha, cpol, 1'b1, 1'b1});
    tick(2);
    mcpol = cpol; mcpha = cpha; monCnt = 0; monByte = '0;
    check(sckOut == cpol, "R4 idle level before byte", sckOut, cpol);
    check(sckOe && mosiOe && !misoOe, "R11 master enables", {sckOe, mosiOe, misoOe}, 3'b110);
    busWrite(2'd2, tx);
    cycles = 0;
    peek(2'd1, d);
    while (!d[0] && cycles < 2000) begin
      tick(1); cycles++;
      peek(2'd1, d);
    end
    check(cycles == 16 * half, "R3 byte duration", cycles[15:0], 16'(16 * half));
    tick(2);
    busRead(2'd2, rx);
    expRx = inv ? ~tx : tx;
    check(rx == expRx, "R2 received byte", rx, expRx);
    check(monByte == tx, "R2 MSB-first master-out", monByte, tx);
    check(monCnt == 16, "R2 clock edge count", monCnt[15:0], 16'd16);
    check(sckOut == cpol, "R4 idle level after byte", sckOut, cpol);
  endtask

  task automatic testCollision();
    logic [7:0] d, rx;
    loopInv = 1'b0;
    clearFlags();
    busWrite(2'd0, {2'b00, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1});
    tick(2);
    mcpol = 1'b0; mcpha = 1'b0; monCnt = 0; monByte = '0;
    busWrite(2'd2, 8'hA5);
    tick(20);
    busWrite(2'd2, 8'h3C);
    peek(2'd1, d);
    check(d[2:0] == 3'b010, "R7 collision flag mid-byte", d, 8'h02);
    tick(200);
    peek(2'd1, d);
    check(d[2:0] == 3'b011, "R7 done after collided byte", d, 8'h03);
    busRead(2'd2, rx);
    check(rx == 8'hA5, "R7 exchange unchanged (rx)", rx, 8'hA5);
    check(monByte == 8'hA5, "R7 exchange unchanged (out)", monByte, 8'hA5);
    peek(2'd1, d);
    check(d[1:0] == 2'b11, "R8 data read alone keeps flags", d, 8'h03);
    busRead(2'd1, d);
    busRead(2'd2, d);
    peek(2'd1, d);
    check(d == 8'h00, "R8 flags cleared by status then data", d, 8'h00);
  endtask

  task automatic slaveBits(input logic cpol, input logic cpha, input logic [7:0] tx, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosiIn = tx[i];
        tick(8);
        got[i] = misoOut;
        sckIn = ~cpol;
        tick(8);
        sckIn = cpol;
      end else begin
        sckIn = ~cpol;
        mosiIn = tx[i];
        tick(8);
        got[i] = misoOut;
        sckIn = cpol;
        tick(8);
      end
    end
  endtask

  task automatic slaveXfer(input logic cpol, input logic cpha, input logic [7:0] tx, input logic [7:0] pre);
    logic [7:0] d, rx, got;
    clearFlags();
    sckIn = cpol;
    busWrite(2'd0, {4'b0000, cpha, cpol, 1'b0, 1'b1});
    tick(4);
    busWrite(2'd2, pre);
    ssN = 1'b0;
    tick(8);
    check(misoOe && !sckOe && !mosiOe, "R11 selected slave enables", {sckOe, mosiOe, misoOe}, 3'b001);
    slaveBits(cpol, cpha, tx, got);
    tick(8);
    peek(2'd1, d);
    check(d[0], "R5 slave done flag", d, 8'h01);
    busRead(2'd2, rx);
    check(rx == tx, "R5 slave received byte", rx, tx);
    check(got == pre, "R5 slave master-in byte", got, pre);
    ssN = 1'b1;
    tick(4);
    check(!misoOe, "R11 deselected slave releases", misoOe, 1'b0);
  endtask

  task automatic testSlaveIgnore();
    logic [7:0] d, rx, got;
    clearFlags();
    sckIn = 1'b0;
    busWrite(2'd0, 8'h01);
    tick(4);
    busWrite(2'd2, 8'h96);
    mosiIn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sckIn = ~sckIn;
      tick(4);
    end
    tick(4);
    peek(2'd1, d);
    check(!d[0], "R6 no done while deselected", d, 8'h00);
    check(!misoOe, "R6 no master-in drive while deselected", misoOe, 1'b0);
    ssN = 1'b0;
    tick(8);
    slaveBits(1'b0, 1'b0, 8'h0F, got);
    tick(8);
    check(got == 8'h96, "R6 preload intact after ignored edges", got, 8'h96);
    busRead(2'd2, rx);
    check(rx == 8'h0F, "R6 next selected byte received", rx, 8'h0F);
    ssN = 1'b1;
    tick(4);
  endtask

  task automatic testModeFault();
    logic [7:0] d;
    clearFlags();
    busWrite(2'd0, {2'b00, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1});
    tick(2);
    busWrite(2'd2, 8'h55);
    tick(10);
    ssN = 1'b0;
    tick(4);
    peek(2'd1, d);
    check(d[2], "R9 fault flag set", d, 8'h04);
    peek(2'd0, d);
    check(d[1:0] == 2'b01, "R9 master bit cleared", d, 8'h01);
    check(!sckOe && !mosiOe, "R9 drivers released", {sckOe, mosiOe}, 2'b00);
    tick(300);
    peek(2'd1, d);
    check(!d[0], "R9 aborted byte has no done", d, 8'h04);
    ssN = 1'b1;
    tick(4);
    busRead(2'd2, d);
    busWrite(2'd0, 8'h01);
    peek(2'd1, d);
    check(d[2], "R10 control write alone keeps fault", d, 8'h04);
    busRead(2'd1, d);
    busWrite(2'd0, 8'h01);
    peek(2'd1, d);
    check(!d[2], "R10 status read then control write clears", d, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(2);
    testReset();
    masterXfer(1'b0, 1'b0, 2'd0, 8'hA5, 1'b0);
    masterXfer(1'b1, 1'b0, 2'd1, 8'h3C, 1'b1);
    masterXfer(1'b0, 1'b1, 2'd2, 8'h81, 1'b0);
    masterXfer(1'b1, 1'b1, 2'd3, 8'h6E, 1'b1);
    testCollision();
    slaveXfer(1'b0, 1'b0, 8'hC3, 8'h5A);
    slaveXfer(1'b1, 1'b1, 8'h29, 8'hB4);
    testSlaveIgnore();
    testModeFault();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule